// File: doc/BRIEF.md
# PLL Setting Search Engine

This block searches for the feedback multiplier and the two output dividers of a clock synthesizer. The caller supplies a parent (reference) frequency and a requested output frequency as unsigned integers. The engine returns the setting whose output comes closest to the request without going over it. Each candidate output is the floor of parent × mul / (div1 × 2^div2). The engine tests one candidate per clock in a fixed order and stops as soon as a candidate lands exactly on the request.

The engine is started with a one-cycle `start_i` pulse while it is idle. It raises `busy_o` while it works and pulses `done_o` for one cycle when it finishes. At that point the result registers hold the three fields, the packed setting word, the achieved rate, an exact-match flag and a no-result flag. These registers keep their values until the next search finishes. The search space covers div1 from 5 to 3, div2 from 3 to 0 and mul from 3 to 1023, which makes 12252 candidates at most.

Top module: `pll_search_engine`

## Requirements
- R1: The achieved rate reported with a result equals floor(parent × mul / (div1 × 2^div2)) for the reported fields.
- R2: Candidates are visited with div1 as the outer loop (5 down to 3), div2 as the middle loop (3 down to 0) and mul as the inner loop (3 up to 1023).
- R3: A candidate whose rate exceeds the request is never selected, so a reported rate never exceeds the request.
- R4: The first candidate whose rate equals the request ends the search with that setting, and `exact_o` is 1 (otherwise 0).
- R5: Without an exact match, the result is the candidate with the strictly highest rate at or below the request; on equal rates the earlier-visited candidate is kept.
- R6: `word_o` carries mul in bits 9:0, div1 in bits 12:10 and div2 in bits 14:13.
- R7: If no candidate is at or below the request, the result has `none_o` = 1 and mul, div1, div2, word, rate and exact all zero.
- R8: If the search ends on the k-th visited candidate (k counted from 1), `done_o` is high during exactly the cycle that follows the k-th rising edge after the edge that accepted the start.
- R9: `start_i` is accepted only when the engine is idle. A start while `busy_o` is high, including the cycle in which `done_o` is high, has no effect on the running search or its result.
- R10: After reset, `busy_o`, `done_o` and all result outputs are zero.
- R11: `done_o` lasts one cycle, and the result outputs change only when a search finishes, holding their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| parent_i | input | RATE_W | Parent frequency, captured at start |
| target_i | input | RATE_W | Requested frequency, captured at start |
| busy_o | output | 1 | Search or done cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mul_o | output | MUL_W | Selected multiplier |
| div1_o | output | D1_W | Selected first divider |
| div2_o | output | D2_W | Selected power-of-two divider exponent |
| word_o | output | MUL_W+D1_W+D2_W | Packed setting word |
| rate_o | output | RATE_W | Achieved output rate |
| exact_o | output | 1 | Result equals the request |
| none_o | output | 1 | No candidate at or below the request |

## Verification
The collision that matters most is a new start arriving in the same cycle as the completion pulse. At that moment the engine is still busy, so the start must be dropped, while the result registers are being loaded with the finished search. The bench provokes this by watching for `done_o` and driving a start with different operands in that same cycle. It also drives a start in the middle of a scan. A second collision happens inside the scan loop, where an exact hit and the last candidate can end the search on the same edge. Its result is judged against a behavioural reference search that tracks the expected busy, done and result values on every clock.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } srch_state_e;

endpackage

// File: rtl/pll_srch_cursor.sv
// Walks the candidate space: div1 outer (descending), div2 middle
// (descending), mul inner (ascending). last_o marks the final candidate.
module pll_srch_cursor #(
  parameter int MUL_MIN = 3,
  parameter int MUL_MAX = 1023,
  parameter int MUL_W   = 10,
  parameter int D1_HI   = 5,
  parameter int D1_LO   = 3,
  parameter int D1_W    = 3,
  parameter int D2_HI   = 3,
  parameter int D2_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [MUL_W-1:0] mul_o,
  output logic [D1_W-1:0]  d1_o,
  output logic [D2_W-1:0]  d2_o,
  output logic             last_o
);

  logic mul_wrap_w;
  logic d2_wrap_w;

  assign mul_wrap_w = (mul_o == MUL_W'(MUL_MAX));
  assign d2_wrap_w  = (d2_o == '0);
  assign last_o     = mul_wrap_w && d2_wrap_w && (d1_o == D1_W'(D1_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mul_o <= MUL_W'(MUL_MIN);
      d1_o  <= D1_W'(D1_HI);
      d2_o  <= D2_W'(D2_HI);
    end else if (load_i) begin
      mul_o <= MUL_W'(MUL_MIN);
      d1_o  <= D1_W'(D1_HI);
      d2_o  <= D2_W'(D2_HI);
    end else if (step_i) begin
      if (mul_wrap_w) begin
        mul_o <= MUL_W'(MUL_MIN);
        if (d2_wrap_w) begin
          d2_o <= D2_W'(D2_HI);
          d1_o <= d1_o - D1_W'(1);
        end else begin
          d2_o <= d2_o - D2_W'(1);
        end
      end else begin
        mul_o <= mul_o + MUL_W'(1);
      end
    end
  end

endmodule

// File: rtl/pll_srch_eval.sv
// Scores one candidate: floor(parent*mul/div1) >> div2, then compares
// it with the request and with the best kept so far.
module pll_srch_eval #(
  parameter int RATE_W = 32,
  parameter int MUL_W  = 10,
  parameter int D1_HI  = 5,
  parameter int D1_LO  = 3,
  parameter int D1_W   = 3,
  parameter int D2_W   = 2
) (
  input  logic [RATE_W-1:0] par_i,
  input  logic [RATE_W-1:0] req_i,
  input  logic [MUL_W-1:0]  mul_i,
  input  logic [D1_W-1:0]   d1_i,
  input  logic [D2_W-1:0]   d2_i,
  input  logic              best_v_i,
  input  logic [RATE_W-1:0] best_rate_i,
  output logic [RATE_W-1:0] cand_rate_o,
  output logic              fits_o,
  output logic              exact_o,
  output logic              better_o
);

  localparam int PROD_W = RATE_W + MUL_W;
  localparam int NUM_D1 = D1_HI - D1_LO + 1;

  function automatic logic [PROD_W-1:0] scale(input logic [RATE_W-1:0] p,
                                              input logic [MUL_W-1:0]  m);
    return PROD_W'(p) * PROD_W'(m);
  endfunction

  logic [PROD_W-1:0] prod_w;
  logic [PROD_W-1:0] quot_w [NUM_D1];
  logic [PROD_W-1:0] q1_w;
  logic [PROD_W-1:0] tclk_w;

  assign prod_w = scale(par_i, mul_i);

  // One constant-divisor path per legal div1 value.
  for (genvar g = 0; g < NUM_D1; g++) begin : g_div1
    assign quot_w[g] = prod_w / PROD_W'(D1_LO + g);
  end

  always_comb begin
    q1_w = '0;
    for (int k = 0; k < NUM_D1; k++) begin
      if (d1_i == D1_W'(D1_LO + k)) q1_w = quot_w[k];
    end
  end

  assign tclk_w      = q1_w >> d2_i;
  assign fits_o      = (tclk_w <= PROD_W'(req_i));
  assign cand_rate_o = tclk_w[RATE_W-1:0];
  assign exact_o     = fits_o && (tclk_w == PROD_W'(req_i));
  assign better_o    = fits_o && (!best_v_i || (cand_rate_o > best_rate_i));

endmodule

// File: rtl/pll_search_engine.sv
module pll_search_engine
  import pll_srch_pkg::*;
#(
  parameter int RATE_W  = 32,
  parameter int MUL_MIN = 3,
  parameter int MUL_MAX = 1023,
  parameter int MUL_W   = 10,
  parameter int D1_HI   = 5,
  parameter int D1_LO   = 3,
  parameter int D1_W    = 3,
  parameter int D2_HI   = 3,
  parameter int D2_W    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [RATE_W-1:0]           parent_i,
  input  logic [RATE_W-1:0]           target_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [MUL_W-1:0]            mul_o,
  output logic [D1_W-1:0]             div1_o,
  output logic [D2_W-1:0]             div2_o,
  output logic [MUL_W+D1_W+D2_W-1:0]  word_o,
  output logic [RATE_W-1:0]           rate_o,
  output logic                        exact_o,
  output logic                        none_o
);

  srch_state_e state_q;

  // Named internal events.
  logic accept_w, scan_w, stop_w, step_w;
  logic last_w, fits_w, exact_w, better_w;

  logic [RATE_W-1:0] par_q, req_q;
  logic [MUL_W-1:0]  cur_mul;
  logic [D1_W-1:0]   cur_d1;
  logic [D2_W-1:0]   cur_d2;
  logic [RATE_W-1:0] cand_rate_w;

  logic              best_v_q;
  logic [MUL_W-1:0]  best_mul_q;
  logic [D1_W-1:0]   best_d1_q;
  logic [D2_W-1:0]   best_d2_q;
  logic [RATE_W-1:0] best_rate_q;

  logic              fin_v_w;
  logic [MUL_W-1:0]  fin_mul_w;
  logic [D1_W-1:0]   fin_d1_w;
  logic [D2_W-1:0]   fin_d2_w;
  logic [RATE_W-1:0] fin_rate_w;

  assign accept_w = (state_q == ST_IDLE) && start_i;
  assign scan_w   = (state_q == ST_SCAN);
  assign stop_w   = scan_w && (exact_w || last_w);
  assign step_w   = scan_w && !stop_w;

  pll_srch_cursor #(
    .MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX), .MUL_W(MUL_W),
    .D1_HI(D1_HI), .D1_LO(D1_LO), .D1_W(D1_W),
    .D2_HI(D2_HI), .D2_W(D2_W)
  ) u_cursor (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept_w),
    .step_i(step_w),
    .mul_o (cur_mul),
    .d1_o  (cur_d1),
    .d2_o  (cur_d2),
    .last_o(last_w)
  );

  pll_srch_eval #(
    .RATE_W(RATE_W), .MUL_W(MUL_W),
    .D1_HI(D1_HI), .D1_LO(D1_LO), .D1_W(D1_W), .D2_W(D2_W)
  ) u_eval (
    .par_i      (par_q),
    .req_i      (req_q),
    .mul_i      (cur_mul),
    .d1_i       (cur_d1),
    .d2_i       (cur_d2),
    .best_v_i   (best_v_q),
    .best_rate_i(best_rate_q),
    .cand_rate_o(cand_rate_w),
    .fits_o     (fits_w),
    .exact_o    (exact_w),
    .better_o   (better_w)
  );

  // Best-so-far including the candidate under test this cycle.
  always_comb begin
    fin_v_w    = best_v_q || better_w;
    fin_mul_w  = better_w ? cur_mul     : best_mul_q;
    fin_d1_w   = better_w ? cur_d1      : best_d1_q;
    fin_d2_w   = better_w ? cur_d2      : best_d2_q;
    fin_rate_w = better_w ? cand_rate_w : best_rate_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_w) state_q <= ST_SCAN;
        ST_SCAN: if (stop_w)   state_q <= ST_DONE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q       <= '0;
      req_q       <= '0;
      best_v_q    <= 1'b0;
      best_mul_q  <= '0;
      best_d1_q   <= '0;
      best_d2_q   <= '0;
      best_rate_q <= '0;
    end else if (accept_w) begin
      par_q       <= parent_i;
      req_q       <= target_i;
      best_v_q    <= 1'b0;
      best_mul_q  <= '0;
      best_d1_q   <= '0;
      best_d2_q   <= '0;
      best_rate_q <= '0;
    end else if (scan_w) begin
      best_v_q    <= fin_v_w;
      best_mul_q  <= fin_mul_w;
      best_d1_q   <= fin_d1_w;
      best_d2_q   <= fin_d2_w;
      best_rate_q <= fin_rate_w;
    end
  end

  // Result registers: loaded only on the edge that ends a search.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mul_o   <= '0;
      div1_o  <= '0;
      div2_o  <= '0;
      rate_o  <= '0;
      exact_o <= 1'b0;
      none_o  <= 1'b0;
    end else if (stop_w) begin
      mul_o   <= fin_mul_w;
      div1_o  <= fin_d1_w;
      div2_o  <= fin_d2_w;
      rate_o  <= fin_rate_w;
      exact_o <= exact_w;
      none_o  <= !fin_v_w;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign word_o = {div2_o, div1_o, mul_o};

endmodule

// File: rtl/pll_srch_chk.sv
module pll_srch_chk #(
  parameter int RATE_W  = 32,
  parameter int MUL_MIN = 3,
  parameter int MUL_MAX = 1023,
  parameter int MUL_W   = 10,
  parameter int D1_HI   = 5,
  parameter int D1_LO   = 3,
  parameter int D1_W    = 3,
  parameter int D2_HI   = 3,
  parameter int D2_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              exact_o,
  input logic              none_o,
  input logic [RATE_W-1:0] rate_o,
  input logic [MUL_W-1:0]  mul_o,
  input logic [RATE_W-1:0] req_q,
  input logic              scan_w,
  input logic [MUL_W-1:0]  cur_mul,
  input logic [D1_W-1:0]   cur_d1,
  input logic [D2_W-1:0]   cur_d2
);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rate_o) |-> done_o);

  assert_rate_cap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !none_o) |-> (rate_o <= req_q));

  assert_exact_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exact_o) |-> (rate_o == req_q));

  assert_empty_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && none_o) |-> (rate_o == '0 && mul_o == '0 && !exact_o));

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(req_q));

  assert_cursor_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_w |-> (cur_d1 >= D1_W'(D1_LO) && cur_d1 <= D1_W'(D1_HI) &&
                cur_d2 <= D2_W'(D2_HI) &&
                cur_mul >= MUL_W'(MUL_MIN) && cur_mul <= MUL_W'(MUL_MAX)));

endmodule

bind pll_search_engine pll_srch_chk #(
  .RATE_W(RATE_W), .MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX), .MUL_W(MUL_W),
  .D1_HI(D1_HI), .D1_LO(D1_LO), .D1_W(D1_W), .D2_HI(D2_HI), .D2_W(D2_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .exact_o(exact_o),
  .none_o (none_o),
  .rate_o (rate_o),
  .mul_o  (mul_o),
  .req_q  (req_q),
  .scan_w (scan_w),
  .cur_mul(cur_mul),
  .cur_d1 (cur_d1),
  .cur_d2 (cur_d2)
);

// File: tb/pll_search_engine_bench.sv
`timescale 1ns/1ps
module pll_search_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parent = '0;
  logic [31:0] target = '0;
  logic        busy_o, done_o, exact_o, none_o;
  logic [9:0]  mul_o;
  logic [2:0]  div1_o;
  logic [1:0]  div2_o;
  logic [14:0] word_o;
  logic [31:0] rate_o;

  always #5 clk = ~clk;

  pll_search_engine u_pll_search_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .parent_i(parent), .target_i(target),
    .busy_o(busy_o), .done_o(done_o),
    .mul_o(mul_o), .div1_o(div1_o), .div2_o(div2_o),
    .word_o(word_o), .rate_o(rate_o), .exact_o(exact_o), .none_o(none_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference search straight from the requirements.
  function automatic void ref_search(input longint p, input longint r,
      output longint bm, output longint bd1, output longint bd2,
      output longint brate, output bit ex, output bit nn, output int n);
    bit found = 0;
    bm = 0; bd1 = 0; bd2 = 0; brate = 0; ex = 0; nn = 0; n = 0;
    for (int d1 = 5; d1 >= 3; d1--)
      for (int d2 = 3; d2 >= 0; d2--)
        for (int m = 3; m <= 1023; m++) begin
          longint t;
          n++;
          t = (p * m) / (d1 * (longint'(1) << d2));
          if (t <= r) begin
            if (t == r) begin
              bm = m; bd1 = d1; bd2 = d2; brate = t; ex = 1;
              return;
            end
            if (!found || t > brate) begin
              found = 1; bm = m; bd1 = d1; bd2 = d2; brate = t;
            end
          end
        end
    nn = !found;
  endfunction

  // Cycle model: 0 idle, 1 scanning, 2 done cycle.
  int     m_state = 0;
  int     m_cnt = 0;
  int     m_n = 0;
  longint m_req = 0;
  longint e_mul, e_d1, e_d2, e_rate;
  bit     e_ex, e_nn;
  longint o_mul = 0, o_d1 = 0, o_d2 = 0, o_rate = 0;
  bit     o_ex = 0, o_nn = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      o_mul = 0; o_d1 = 0; o_d2 = 0; o_rate = 0; o_ex = 0; o_nn = 0;
    end else begin
      case (m_state)
        0: if (start) begin
          m_req = target;
          ref_search(parent, target, e_mul, e_d1, e_d2, e_rate, e_ex, e_nn, m_n);
          m_cnt = 1;
          m_state = 1;
        end
        1: if (m_cnt == m_n) begin
          o_mul = e_mul; o_d1 = e_d1; o_d2 = e_d2; o_rate = e_rate;
          o_ex = e_ex; o_nn = e_nn;
          m_state = 2;
        end else m_cnt++;
        default: m_state = 0;
      endcase
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      string rt;
      rt = (m_state == 2) ? cur_tag : "R11";
      chk(done_o == (m_state == 2), "R8", "done", done_o, m_state == 2);
      chk(busy_o == (m_state != 0), "R9", "busy", busy_o, m_state != 0);
      chk(mul_o == o_mul, rt, "mul", mul_o, o_mul);
      chk(div1_o == o_d1, rt, "div1", div1_o, o_d1);
      chk(div2_o == o_d2, rt, "div2", div2_o, o_d2);
      chk(rate_o == o_rate, (m_state == 2) ? "R1" : "R11", "rate", rate_o, o_rate);
      chk(word_o == o_mul + (o_d1 << 10) + (o_d2 << 13), "R6", "word", word_o,
          o_mul + (o_d1 << 10) + (o_d2 << 13));
      chk(exact_o == o_ex, "R4", "exact", exact_o, o_ex);
      chk(none_o == o_nn, "R7", "none", none_o, o_nn);
      if (done_o && !none_o)
        chk(rate_o <= m_req, "R3", "rate above request", rate_o, m_req);
    end
  end

  task automatic launch(input longint p, input longint r, input string tag);
    @(negedge clk);
    parent = 32'(p); target = 32'(r); start = 1'b1; cur_tag = tag;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy_o == 0 && done_o == 0, "R10", "busy/done in reset", busy_o + done_o, 0);
    chk(word_o == 0 && rate_o == 0 && !exact_o && !none_o, "R10",
        "results in reset", rate_o + word_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4: exact hit on the 8th candidate (div1=5, div2=3, mul=10)
    launch(24, 6, "R2"); wait_done(); @(negedge clk);
    // R7: nothing at or below the request, full scan
    launch(1000, 10, "R7"); wait_done(); @(negedge clk);
    // R3: request far above every candidate, best is the last candidate
    launch(1, 2000, "R3"); wait_done(); @(negedge clk);
    // R5: rate 50 reached several times, first one (mul=5,div1=5,div2=3) kept
    launch(400, 55, "R5"); wait_done(); @(negedge clk);
    // R5: later candidate strictly better (93 beats 75)
    launch(1000, 99, "R5"); wait_done(); @(negedge clk);

    // R9: start with other operands in the middle of a scan
    launch(24, 600, "R2");
    repeat (5) @(negedge clk);
    parent = 32'd7; target = 32'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    // R9: start in the same cycle as the done pulse is dropped
    parent = 32'd1000; target = 32'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R9", "start during done accepted", busy_o, 0);

    // Back-to-back searches right after idle
    launch(24, 12, "R4"); wait_done();
    launch(50, 37, "R2"); wait_done();
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule